// File: doc/BRIEF.md
# Gold-Code BPSK Chip Spreader

This block turns a stream of data symbols into a spread BPSK chip stream for a burst transmitter. A 2047-chip Gold code is formed from two 11-bit maximal-length shift registers whose starting states are programmable. The code runs at the processing clock divided by a power of two. The symbol rate comes from a separate 32-bit phase accumulator, so symbol edges do not need to line up with chips or with the code period. The block emits one sample per clock while a burst is active. Each sample is the current code chip multiplied by the current data symbol. A strobe marks the first sample of every chip.

The upstream framer holds `burst_active` high for the length of a burst and presents the current symbol on `sym_bit`. When `sym_take` is high, the block consumes that bit at the clock edge, and the framer then presents the next one. Every field of a burst is spread the same way: the preambles, the sync word and the coded data. The Q output carries the same chip as I. A control bit negates Q to invert the spectrum.

Top module: `gcs_chip_spreader`

## Requirements
- R1: While `rst` is high, and in the cycle after any clock edge at which `burst_active` was low, `sample_valid` and `chip_strobe` are 0 and `chip_i` and `chip_q` are 0. `sym_take` is 0 whenever `burst_active` is low.
- R2: Each clock edge at which `burst_active` is high produces one sample, visible on the outputs after that edge with `sample_valid` = 1.
- R3: A chip lasts 2^n samples, where n is `cfg_rate_exp` and the value 0 is treated as 1. `chip_strobe` is 1 on the first sample of a burst and on every 2^n-th sample after it, and 0 on all other samples.
- R4: Register A (bits [10:0]) advances as new[10] = a[0]^a[2] with a shift toward bit 0. Register C advances as new[10] = c[0]^c[2]^c[5]^c[8] with the same shift. The code bit is a[0]^c[0]. Both registers advance once, after the last sample of each chip.
- R5: At the start of each burst both registers hold `cfg_init_a` and `cfg_init_c`. An all-zero initial value is replaced with 11'h001.
- R6: After chip 2046 both registers are reloaded with their initial values, so chip 2047 of a burst repeats chip 0.
- R7: The 32-bit symbol phase is 0 at the start of a burst. It adds `cfg_sym_inc` on every active clock. `sym_take` is 1 in exactly those active cycles where the addition carries out of bit 31, and the symbol bit is replaced after that edge.
- R8: Sample chip = code bit XOR `sym_bit`. A result of 0 is sent as +1 (2'b01) and a result of 1 as -1 (2'b11) on `chip_i`.
- R9: `chip_q` equals `chip_i` when `cfg_q_invert` is 0 and equals its negation when `cfg_q_invert` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock, one sample per cycle |
| rst | input | 1 | Synchronous active-high reset |
| burst_active | input | 1 | High for the duration of a burst |
| cfg_rate_exp | input | 4 | Chip length exponent n (samples per chip = 2^n) |
| cfg_init_a | input | 11 | Initial state of register A |
| cfg_init_c | input | 11 | Initial state of register C |
| cfg_sym_inc | input | 32 | Symbol phase increment, fsym * 2^32 / fclk |
| cfg_q_invert | input | 1 | Negate the Q output |
| sym_bit | input | 1 | Current data symbol |
| sym_take | output | 1 | Current symbol is consumed at this edge |
| sample_valid | output | 1 | Output sample is valid |
| chip_strobe | output | 1 | First sample of a chip |
| chip_i | output | 2 | Signed I chip, +1 or -1 |
| chip_q | output | 2 | Signed Q chip, +1 or -1 |

## Verification
The bench sweeps several chip exponents: 0, which is clamped to 1, then 1, 3 and 15. For each one it compares every sample against an arithmetic model of the two registers, the divider and the phase accumulator. Symbol increments above one half force symbol changes in the middle of a chip. A design that gated the data per chip, or sampled the symbol at the wrong edge, would emit wrong signs there. Zero initial values catch a design that lets a register lock up at zero, which would give a constant code. A design that drops the clamp of exponent 0 would emit a strobe every cycle. One run crosses the 2047-chip boundary and compares chip 2047 with chip 0. A second burst with the same settings checks that the state restarts rather than continuing from the previous burst.

// File: rtl/gcs_pkg.sv
package gcs_pkg;

    localparam int LFSR_W    = 11;
    localparam int CODE_LEN  = (1 << LFSR_W) - 1;
    localparam int PHASE_W   = 32;
    localparam int EXP_W     = 4;

    localparam logic [LFSR_W-1:0] TAPS_A = 11'b000_0000_0101;
    localparam logic [LFSR_W-1:0] TAPS_C = 11'b001_0010_0101;

    typedef logic signed [1:0] chip_t;

    localparam chip_t CHIP_POS  = 2'sb01;
    localparam chip_t CHIP_NEG  = 2'sb11;
    localparam chip_t CHIP_NONE = 2'sb00;

    typedef struct packed {
        logic  valid;
        logic  strobe;
        chip_t i;
        chip_t q;
    } sample_t;

    localparam sample_t SAMPLE_IDLE = '{valid: 1'b0, strobe: 1'b0,
                                        i: CHIP_NONE, q: CHIP_NONE};

    function automatic logic [LFSR_W-1:0] seed_fix(input logic [LFSR_W-1:0] s);
        return (s == '0) ? LFSR_W'(1) : s;
    endfunction

    function automatic chip_t map_chip(input logic b);
        return b ? CHIP_NEG : CHIP_POS;
    endfunction

endpackage

// File: rtl/gcs_chip_timer.sv
module gcs_chip_timer #(
    parameter int EXP_W = gcs_pkg::EXP_W,
    parameter int DIV_W = (1 << EXP_W) - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [EXP_W-1:0] rate_exp,
    output logic             chip_first,
    output logic             chip_last
);
    logic [DIV_W-1:0] div_cnt;
    logic [EXP_W-1:0] eff_exp;
    logic [DIV_W-1:0] limit;

    always_comb begin
        eff_exp = (rate_exp == '0) ? EXP_W'(1) : rate_exp;
        limit   = ~({DIV_W{1'b1}} << eff_exp);
    end

    assign chip_first = run && (div_cnt == '0);
    assign chip_last  = run && (div_cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            div_cnt <= '0;
        end else if (div_cnt == limit) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/gcs_lfsr.sv
module gcs_lfsr #(
    parameter int                W    = gcs_pkg::LFSR_W,
    parameter logic [W-1:0]      TAPS = gcs_pkg::TAPS_A
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] seed,
    output logic [W-1:0] state
);
    logic fb;

    assign fb = ^(state & TAPS);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= W'(1);
        end else if (load) begin
            state <= seed;
        end else if (step) begin
            state <= {fb, state[W-1:1]};
        end
    end

endmodule

// File: rtl/gcs_gold_gen.sv
module gcs_gold_gen #(
    parameter int W   = gcs_pkg::LFSR_W,
    parameter int LEN = (1 << W) - 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         advance,
    input  logic [W-1:0] init_a,
    input  logic [W-1:0] init_c,
    output logic         code_bit
);
    localparam int NREG  = 2;
    localparam int IDX_W = $clog2(LEN);

    logic [W-1:0]     seeds  [NREG];
    logic [W-1:0]     states [NREG];
    logic [IDX_W-1:0] chip_idx;
    logic             wrap;
    logic             do_load;
    logic             do_step;

    assign seeds[0] = gcs_pkg::seed_fix(init_a);
    assign seeds[1] = gcs_pkg::seed_fix(init_c);

    assign wrap    = advance && (chip_idx == IDX_W'(LEN - 1));
    assign do_load = !run || wrap;
    assign do_step = advance && !wrap;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [W-1:0] TP = (g == 0) ? gcs_pkg::TAPS_A : gcs_pkg::TAPS_C;
        gcs_lfsr #(.W(W), .TAPS(TP)) lfsr_i (
            .clk   (clk),
            .rst   (rst),
            .load  (do_load),
            .step  (do_step),
            .seed  (seeds[g]),
            .state (states[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst || do_load) begin
            chip_idx <= '0;
        end else if (do_step) begin
            chip_idx <= chip_idx + 1'b1;
        end
    end

    assign code_bit = states[0][0] ^ states[1][0];

endmodule

// File: rtl/gcs_symbol_nco.sv
module gcs_symbol_nco #(
    parameter int W = gcs_pkg::PHASE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] inc,
    output logic         carry
);
    logic [W-1:0] phase;
    logic [W:0]   sum;

    assign sum   = {1'b0, phase} + {1'b0, inc};
    assign carry = run && sum[W];

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            phase <= '0;
        end else begin
            phase <= sum[W-1:0];
        end
    end

endmodule

// File: rtl/gcs_chip_spreader.sv
module gcs_chip_spreader #(
    parameter int LFSR_W  = gcs_pkg::LFSR_W,
    parameter int PHASE_W = gcs_pkg::PHASE_W,
    parameter int EXP_W   = gcs_pkg::EXP_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               burst_active,
    input  logic [EXP_W-1:0]   cfg_rate_exp,
    input  logic [LFSR_W-1:0]  cfg_init_a,
    input  logic [LFSR_W-1:0]  cfg_init_c,
    input  logic [PHASE_W-1:0] cfg_sym_inc,
    input  logic               cfg_q_invert,
    input  logic               sym_bit,
    output logic               sym_take,
    output logic               sample_valid,
    output logic               chip_strobe,
    output logic signed [1:0]  chip_i,
    output logic signed [1:0]  chip_q
);
    import gcs_pkg::*;

    logic    chip_first;
    logic    chip_last;
    logic    code_bit;
    logic    nco_carry;
    sample_t smp_next;
    sample_t smp_q;

    gcs_chip_timer #(.EXP_W(EXP_W)) timer_i (
        .clk        (clk),
        .rst        (rst),
        .run        (burst_active),
        .rate_exp   (cfg_rate_exp),
        .chip_first (chip_first),
        .chip_last  (chip_last)
    );

    gcs_gold_gen #(.W(LFSR_W)) gold_i (
        .clk      (clk),
        .rst      (rst),
        .run      (burst_active),
        .advance  (chip_last),
        .init_a   (cfg_init_a),
        .init_c   (cfg_init_c),
        .code_bit (code_bit)
    );

    gcs_symbol_nco #(.W(PHASE_W)) nco_i (
        .clk   (clk),
        .rst   (rst),
        .run   (burst_active),
        .inc   (cfg_sym_inc),
        .carry (nco_carry)
    );

    assign sym_take = nco_carry;

    always_comb begin
        smp_next.valid  = 1'b1;
        smp_next.strobe = chip_first;
        smp_next.i      = map_chip(code_bit ^ sym_bit);
        smp_next.q      = cfg_q_invert ? -smp_next.i : smp_next.i;
    end

    always_ff @(posedge clk) begin
        if (rst || !burst_active) begin
            smp_q <= SAMPLE_IDLE;
        end else begin
            smp_q <= smp_next;
        end
    end

    assign sample_valid = smp_q.valid;
    assign chip_strobe  = smp_q.strobe;
    assign chip_i       = smp_q.i;
    assign chip_q       = smp_q.q;

endmodule

// File: rtl/gcs_chip_spreader_chk.sv
module gcs_chip_spreader_chk (
    input logic              clk,
    input logic              rst,
    input logic              burst_active,
    input logic              cfg_q_invert,
    input logic              sym_take,
    input logic              sample_valid,
    input logic              chip_strobe,
    input logic signed [1:0] chip_i,
    input logic signed [1:0] chip_q
);
    // R1
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !sample_valid |-> (chip_i == 2'sb00 && chip_q == 2'sb00 && !chip_strobe));

    // R1
    take_idle_chk: assert property (@(posedge clk) disable iff (rst)
        sym_take |-> burst_active);

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        burst_active |=> sample_valid);

    // R8
    chip_level_chk: assert property (@(posedge clk) disable iff (rst)
        sample_valid |-> (chip_i == 2'sb01 || chip_i == 2'sb11));

    // R9
    q_relation_chk: assert property (@(posedge clk) disable iff (rst)
        sample_valid |-> (chip_q == ($past(cfg_q_invert) ? -chip_i : chip_i)));

    // R3
    strobe_gap_chk: assert property (@(posedge clk) disable iff (rst)
        chip_strobe |=> !chip_strobe);

    // R3
    first_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sample_valid) |-> chip_strobe);

endmodule

bind gcs_chip_spreader gcs_chip_spreader_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .burst_active (burst_active),
    .cfg_q_invert (cfg_q_invert),
    .sym_take     (sym_take),
    .sample_valid (sample_valid),
    .chip_strobe  (chip_strobe),
    .chip_i       (chip_i),
    .chip_q       (chip_q)
);

// File: tb/gcs_chip_spreader_tb.sv
module gcs_chip_spreader_tb_top;

    logic              clk = 1'b0;
    logic              rst;
    logic              burst_active;
    logic [3:0]        cfg_rate_exp;
    logic [10:0]       cfg_init_a;
    logic [10:0]       cfg_init_c;
    logic [31:0]       cfg_sym_inc;
    logic              cfg_q_invert;
    logic              sym_bit;
    logic              sym_take;
    logic              sample_valid;
    logic              chip_strobe;
    logic signed [1:0] chip_i;
    logic signed [1:0] chip_q;

    int checks   = 0;
    int failures = 0;

    always #5 clk = ~clk;

    gcs_chip_spreader dut_i (
        .clk          (clk),
        .rst          (rst),
        .burst_active (burst_active),
        .cfg_rate_exp (cfg_rate_exp),
        .cfg_init_a   (cfg_init_a),
        .cfg_init_c   (cfg_init_c),
        .cfg_sym_inc  (cfg_sym_inc),
        .cfg_q_invert (cfg_q_invert),
        .sym_bit      (sym_bit),
        .sym_take     (sym_take),
        .sample_valid (sample_valid),
        .chip_strobe  (chip_strobe),
        .chip_i       (chip_i),
        .chip_q       (chip_q)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    function automatic bit data_of(input int k);
        logic [31:0] v;
        v = (k * 29) ^ (k >> 3) ^ 32'h5;
        return v[0];
    endfunction

    function automatic int enc(input bit b);
        return b ? -1 : 1;
    endfunction

    task automatic check_idle(input string req);
        chk(sample_valid == 1'b0, req, sample_valid, 0);
        chk(chip_i == 2'sb00 && chip_q == 2'sb00 && chip_strobe == 1'b0, req,
            {chip_strobe, chip_i, chip_q}, 0);
        chk(sym_take == 1'b0, req, sym_take, 0);
    endtask

    // One burst compared sample by sample against an arithmetic model.
    task automatic run_burst(input int n, input logic [10:0] ia, input logic [10:0] ic,
                             input logic [31:0] inc, input bit qinv, input int ncyc,
                             input bit chk_period, input bit chk_zero_seed);
        logic [10:0] m_a, m_c, sa, sc;
        logic [32:0] sum;
        int  lim, m_div, m_idx, symcnt;
        bit  d, code, carry, exp_strobe;
        int  e_valid, e_strobe, e_i, e_q, e_take;
        int  f_act, f_exp;
        string f_req;
        bit  code0, code2047;
        logic [31:0] m_phase;
        cfg_rate_exp = 4'(n);
        cfg_init_a   = ia;
        cfg_init_c   = ic;
        cfg_sym_inc  = inc;
        cfg_q_invert = qinv;
        burst_active = 1'b0;
        @(posedge clk);
        @(negedge clk);
        sa = (ia == 0) ? 11'h001 : ia;
        sc = (ic == 0) ? 11'h001 : ic;
        m_a = sa; m_c = sc;
        lim = (1 << ((n == 0) ? 1 : n)) - 1;
        m_div = 0; m_idx = 0; m_phase = 0; symcnt = 0;
        d = data_of(0);
        e_valid = 0; e_strobe = 0; e_i = 0; e_q = 0; e_take = 0;
        f_act = 0; f_exp = 0; f_req = "";
        code0 = 0; code2047 = 0;
        for (int t = 0; t < ncyc; t++) begin
            burst_active = 1'b1;
            sym_bit = d;
            #1;
            sum   = {1'b0, m_phase} + {1'b0, inc};
            carry = sum[32];
            if (sym_take !== carry) begin
                if (e_take == 0) begin f_req = "R7 sym_take"; f_act = sym_take; f_exp = carry; end
                e_take++;
            end
            code = m_a[0] ^ m_c[0];
            exp_strobe = (m_div == 0);
            @(posedge clk);
            m_phase = sum[31:0];
            if (m_div == lim) begin
                m_div = 0;
                if (m_idx == 2046) begin
                    m_a = sa; m_c = sc; m_idx = 0;
                end else begin
                    m_a = {m_a[0] ^ m_a[2], m_a[10:1]};
                    m_c = {m_c[0] ^ m_c[2] ^ m_c[5] ^ m_c[8], m_c[10:1]};
                    m_idx++;
                end
            end else begin
                m_div++;
            end
            @(negedge clk);
            if (sample_valid !== 1'b1) begin
                if (e_valid == 0 && f_req == "") begin f_req = "R2 valid"; f_act = sample_valid; f_exp = 1; end
                e_valid++;
            end
            if (chip_strobe !== exp_strobe) begin
                if (e_strobe == 0 && f_req == "") begin f_req = "R3 strobe"; f_act = chip_strobe; f_exp = exp_strobe; end
                e_strobe++;
            end
            if (int'(chip_i) != enc(code ^ d)) begin
                if (e_i == 0 && f_req == "") begin f_req = "R4/R8 chip_i"; f_act = chip_i; f_exp = enc(code ^ d); end
                e_i++;
            end
            if (int'(chip_q) != (qinv ? -enc(code ^ d) : enc(code ^ d))) begin
                if (e_q == 0 && f_req == "") begin f_req = "R9 chip_q"; f_act = chip_q; f_exp = qinv ? -enc(code ^ d) : enc(code ^ d); end
                e_q++;
            end
            if (t == 0) code0 = (chip_i == 2'sb11) ^ d;
            if (t == 2047 * (lim + 1)) code2047 = (chip_i == 2'sb11) ^ d;
            if (carry) begin
                symcnt++;
                d = data_of(symcnt);
            end
        end
        // R2 sample valid every active cycle
        chk(e_valid == 0, (e_valid == 0) ? "R2" : f_req, e_valid, 0);
        // R3 chip strobe spacing
        chk(e_strobe == 0, (e_strobe == 0) ? "R3" : f_req, e_strobe, 0);
        // R4 R8 code and chip mapping
        chk(e_i == 0, (e_i == 0) ? "R4 R8" : f_req, e_i, 0);
        // R9 Q channel
        chk(e_q == 0, (e_q == 0) ? "R9" : f_req, e_q, 0);
        // R7 symbol phase carry
        chk(e_take == 0, (e_take == 0) ? "R7" : f_req, e_take, 0);
        if (chk_period) begin
            // R6 chip 2047 repeats chip 0
            chk(code2047 == code0, "R6 period restart", code2047, code0);
        end
        if (chk_zero_seed) begin
            // R5 zero seed replaced with 1: first code bit is 1^1 = 0
            chk(code0 == 1'b0, "R5 zero seed", code0, 0);
        end
        burst_active = 1'b0;
        @(posedge clk);
        @(negedge clk);
        // R1 idle after burst
        check_idle("R1 after burst");
    endtask

    initial begin
        #1500000;
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        summary();
    end

    initial begin
        rst = 1'b1;
        burst_active = 1'b0;
        cfg_rate_exp = 4'd1;
        cfg_init_a = 11'h1;
        cfg_init_c = 11'h1;
        cfg_sym_inc = 32'h1000_0000;
        cfg_q_invert = 1'b0;
        sym_bit = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check_idle("R1 reset");
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check_idle("R1 idle");

        // R6 across the code period, two samples per chip
        run_burst(1, 11'h5A3, 11'h1F0, 32'h4000_0000, 1'b0, 4200, 1'b1, 1'b0);
        // R5 zero seeds, exponent 0 clamped (R3), Q inverted
        run_burst(0, 11'h000, 11'h000, 32'h0123_4567, 1'b1, 3000, 1'b0, 1'b1);
        // mid-chip symbol changes, eight samples per chip
        run_burst(3, 11'h7FF, 11'h001, 32'h9000_0000, 1'b1, 3000, 1'b0, 1'b0);
        // longest chip: only the first sample carries a strobe
        run_burst(15, 11'h2AA, 11'h555, 32'hFFFF_FFFF, 1'b0, 1000, 1'b0, 1'b0);
        // second burst with first settings: restart from seeds
        run_burst(1, 11'h5A3, 11'h1F0, 32'h4000_0000, 1'b0, 600, 1'b0, 1'b0);

        summary();
    end

endmodule